// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner

This block presents a three-and-a-half digit conversion result on one shared 4-bit BCD bus, one digit at a time. Four active-high digit-select lines show which digit the bus is carrying. A one-cycle end-of-conversion strobe captures the result into an internal register and restarts the scan at the half-digit slot. The scan then steps toward the least significant digit and wraps back to the top, so it keeps refreshing until the next strobe. Each select stays on for 18 clocks and is followed by a 2-clock gap with every select low, which lets the bus settle. One slot therefore takes 20 clocks and a whole pass takes 80.

The top slot does not carry an ordinary digit. It packs the half digit with the sign and the two range flags. The three lower slots carry plain BCD digits from the captured result. The strobe and the result inputs are plain control pins. A result is taken on any cycle where the strobe is high, and the block never pushes back. If a strobe arrives in the middle of a pass, that pass is dropped and a new one begins.

Top module: `digit_scanner`

## Requirements
- R1: After reset, all digit selects are low and the bus is 0 until the first end-of-conversion strobe is sampled.
- R2: On the cycle after the strobe is sampled high, the half-digit select (digit_sel[3]) is high.
- R3: The selects step in the order digit_sel[3], digit_sel[2], digit_sel[1], digit_sel[0], then wrap back to digit_sel[3].
- R4: At most one digit select is high in any cycle.
- R5: Each select stays high for exactly 18 consecutive cycles. Two consecutive selects are separated by exactly 2 cycles with all selects low.
- R6: Successive rises of digit_sel[3] within an uninterrupted scan are exactly 80 cycles apart.
- R7: While digit_sel[2], digit_sel[1] or digit_sel[0] is high, the bus carries full_digits[11:8], full_digits[7:4] or full_digits[3:0] respectively, as captured.
- R8: While digit_sel[3] is high, the bus carries the status word: bit 0 is the half digit, bit 1 is polarity, bit 2 is under-range and bit 3 is over-range.
- R9: Whenever no select is high, the bus is 0.
- R10: The bus is driven from values captured at the strobe. Changes on the result inputs without a strobe have no effect on the bus, and the bus stays stable for the whole time a select is high.
- R11: A strobe that arrives mid-scan, including during the half-digit hold or during a blanking gap, restarts the scan at digit_sel[3] with the newly captured result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| eoc_strobe | input | 1 | End-of-conversion pulse; captures the result and restarts the scan |
| full_digits | input | 12 | Three BCD digits, most significant in bits 11:8 |
| half_digit | input | 1 | Leading half digit (0 or 1) |
| polarity | input | 1 | Sign of the result |
| under_range | input | 1 | Under-range flag |
| over_range | input | 1 | Over-range flag |
| digit_sel | output | 4 | One-hot digit selects; bit 3 is the half-digit slot |
| bcd_bus | output | 4 | Multiplexed BCD or status data |

## Verification
The hardest case to reach from the ports is a restart that leaves no visible edge on the selects. If a strobe lands while digit_sel[3] is already high, the select simply stays high and only the hold count and the data show that the scan restarted. A strobe that falls inside a blanking gap is similarly subtle. The stimulus reaches both cases by counting clocks from the capture edge. It issues a new strobe 5 cycles into the half-digit hold, then at the first blanking cycle, and also in the middle of the third slot. For each strobe, the queued expectations of the abandoned pass are dropped and replaced with those of the new result. Between strobes, the result inputs are scrambled to show that only the captured value reaches the bus.

// File: rtl/digit_scanner_pkg.sv
package digit_scanner_pkg;

  // Fields of the half-digit slot, MSB first: over, under, sign, half
  typedef struct packed {
    logic over;
    logic under;
    logic sign;
    logic half;
  } top_slot_t;

  localparam int TOP_SLOT_W = $bits(top_slot_t);

endpackage

// File: rtl/dscan_capture.sv
module dscan_capture
  import digit_scanner_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter int N_FULL  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [N_FULL*DIGIT_W-1:0] full_in,
  input  top_slot_t                 status_in,
  output logic [N_FULL*DIGIT_W-1:0] full_q,
  output top_slot_t                 status_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q   <= '0;
      status_q <= '0;
    end else if (load) begin
      full_q   <= full_in;
      status_q <= status_in;
    end
  end

endmodule

// File: rtl/dscan_timer.sv
module dscan_timer #(
  parameter int SLOTS      = 4,
  parameter int HOLD_CLKS  = 18,
  parameter int GAP_CLKS   = 2,
  localparam int SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              show
);

  localparam int SLOT_CLKS = HOLD_CLKS + GAP_CLKS;
  localparam int TICK_W    = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;

  logic              running_q;
  logic [TICK_W-1:0] tick_q;
  logic [SLOT_W-1:0] slot_q;
  logic              slot_end;
  logic              last_slot;

  assign slot_end  = (tick_q == TICK_W'(SLOT_CLKS - 1));
  assign last_slot = (slot_q == SLOT_W'(SLOTS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      running_q <= 1'b0;
      tick_q    <= '0;
      slot_q    <= '0;
    end else if (restart) begin
      running_q <= 1'b1;
      tick_q    <= '0;
      slot_q    <= '0;
    end else if (running_q) begin
      if (slot_end) begin
        tick_q <= '0;
        slot_q <= last_slot ? '0 : slot_q + 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign slot_idx = slot_q;
  assign show     = running_q && (tick_q < TICK_W'(HOLD_CLKS));

endmodule

// File: rtl/dscan_slot_mux.sv
module dscan_slot_mux #(
  parameter int DIGIT_W  = 4,
  parameter int N_FULL   = 3,
  localparam int SLOTS   = N_FULL + 1,
  localparam int SLOT_W  = $clog2(SLOTS)
) (
  input  logic                      show,
  input  logic [SLOT_W-1:0]         slot_idx,
  input  logic [DIGIT_W-1:0]        top_word,
  input  logic [N_FULL*DIGIT_W-1:0] full_q,
  output logic [SLOTS-1:0]          sel,
  output logic [DIGIT_W-1:0]        bus
);

  logic [DIGIT_W-1:0] words [SLOTS];

  // Slot 0 is the half-digit slot on the highest select line
  assign words[0] = top_word;

  for (genvar s = 1; s < SLOTS; s++) begin : g_full
    assign words[s] = full_q[(N_FULL-s)*DIGIT_W +: DIGIT_W];
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_sel
    assign sel[SLOTS-1-s] = show && (slot_idx == SLOT_W'(s));
  end

  assign bus = show ? words[slot_idx] : '0;

endmodule

// File: rtl/digit_scanner.sv
module digit_scanner
  import digit_scanner_pkg::*;
#(
  parameter int DIGIT_W   = 4,
  parameter int N_FULL    = 3,
  parameter int HOLD_CLKS = 18,
  parameter int GAP_CLKS  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      eoc_strobe,
  input  logic [N_FULL*DIGIT_W-1:0] full_digits,
  input  logic                      half_digit,
  input  logic                      polarity,
  input  logic                      under_range,
  input  logic                      over_range,
  output logic [N_FULL:0]           digit_sel,
  output logic [DIGIT_W-1:0]        bcd_bus
);

  localparam int SLOTS  = N_FULL + 1;
  localparam int SLOT_W = $clog2(SLOTS);

  top_slot_t                 status_in;
  top_slot_t                 status_q;
  logic [N_FULL*DIGIT_W-1:0] full_q;
  logic [SLOT_W-1:0]         slot_idx;
  logic                      show;
  logic [DIGIT_W-1:0]        top_word;

  assign status_in = '{over: over_range, under: under_range,
                       sign: polarity,   half: half_digit};
  assign top_word  = DIGIT_W'(status_q);

  dscan_capture #(.DIGIT_W(DIGIT_W), .N_FULL(N_FULL)) u_capture (
    .clk       (clk),
    .rst       (rst),
    .load      (eoc_strobe),
    .full_in   (full_digits),
    .status_in (status_in),
    .full_q    (full_q),
    .status_q  (status_q)
  );

  dscan_timer #(.SLOTS(SLOTS), .HOLD_CLKS(HOLD_CLKS), .GAP_CLKS(GAP_CLKS)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .restart  (eoc_strobe),
    .slot_idx (slot_idx),
    .show     (show)
  );

  dscan_slot_mux #(.DIGIT_W(DIGIT_W), .N_FULL(N_FULL)) u_mux (
    .show     (show),
    .slot_idx (slot_idx),
    .top_word (top_word),
    .full_q   (full_q),
    .sel      (digit_sel),
    .bus      (bcd_bus)
  );

endmodule

// File: rtl/digit_scanner_checker.sv
module digit_scanner_checker #(
  parameter int DIGIT_W   = 4,
  parameter int N_FULL    = 3,
  parameter int HOLD_CLKS = 18,
  parameter int GAP_CLKS  = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               eoc_strobe,
  input logic [N_FULL:0]    digit_sel,
  input logic [DIGIT_W-1:0] bcd_bus
);

  localparam int NS = N_FULL + 1;
  localparam int CW = $clog2(HOLD_CLKS + GAP_CLKS + 2) + 1;

  logic          started;
  logic          eoc_d;
  logic [NS-1:0] prev_sel;
  logic [NS-1:0] last_nz;
  logic [CW-1:0] hi_run;
  logic [CW-1:0] lo_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      started  <= 1'b0;
      eoc_d    <= 1'b0;
      prev_sel <= '0;
      last_nz  <= '0;
      hi_run   <= '0;
      lo_run   <= '0;
    end else begin
      eoc_d    <= eoc_strobe;
      prev_sel <= digit_sel;
      if (eoc_strobe) started <= 1'b1;
      if (digit_sel != '0) begin
        last_nz <= digit_sel;
        hi_run  <= (digit_sel == prev_sel && !eoc_d) ? hi_run + 1'b1 : CW'(1);
      end else begin
        lo_run  <= (prev_sel == '0) ? lo_run + 1'b1 : CW'(1);
      end
    end
  end

  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !started |-> (digit_sel == '0 && bcd_bus == '0));

  p_msd_first_r2: assert property (@(posedge clk) disable iff (rst)
    eoc_strobe |=> (digit_sel == {1'b1, {N_FULL{1'b0}}}));

  p_step_order_r3: assert property (@(posedge clk) disable iff (rst)
    (digit_sel != '0 && prev_sel == '0 && !eoc_d) |->
      (digit_sel == {last_nz[0], last_nz[NS-1:1]}));

  p_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(digit_sel));

  p_hold_len_r5: assert property (@(posedge clk) disable iff (rst)
    (digit_sel == '0 && prev_sel != '0) |-> (hi_run == CW'(HOLD_CLKS)));

  p_gap_len_r5: assert property (@(posedge clk) disable iff (rst)
    (digit_sel != '0 && prev_sel == '0 && !eoc_d && started) |->
      (lo_run == CW'(GAP_CLKS)));

  p_blank_bus_r9: assert property (@(posedge clk) disable iff (rst)
    (digit_sel == '0) |-> (bcd_bus == '0));

  p_bus_steady_r10: assert property (@(posedge clk) disable iff (rst)
    (digit_sel != '0 && digit_sel == prev_sel && !eoc_d) |-> $stable(bcd_bus));

endmodule

bind digit_scanner digit_scanner_checker #(
  .DIGIT_W(DIGIT_W), .N_FULL(N_FULL), .HOLD_CLKS(HOLD_CLKS), .GAP_CLKS(GAP_CLKS)
) u_checker (
  .clk        (clk),
  .rst        (rst),
  .eoc_strobe (eoc_strobe),
  .digit_sel  (digit_sel),
  .bcd_bus    (bcd_bus)
);

// File: tb/digit_scanner_bench.sv
module digit_scanner_bench;

  typedef struct {
    logic [3:0] sel;
    logic [3:0] bus;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        eoc_strobe = 1'b0;
  logic [11:0] full_digits = '0;
  logic        half_digit = 1'b0;
  logic        polarity = 1'b0;
  logic        under_range = 1'b0;
  logic        over_range = 1'b0;
  logic [3:0]  digit_sel;
  logic [3:0]  bcd_bus;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   restart_pending = 1'b0;
  bit   finished = 1'b0;

  always #10 clk = ~clk;

  digit_scanner u_digit_scanner (
    .clk(clk), .rst(rst), .eoc_strobe(eoc_strobe), .full_digits(full_digits),
    .half_digit(half_digit), .polarity(polarity), .under_range(under_range),
    .over_range(over_range), .digit_sel(digit_sel), .bcd_bus(bcd_bus)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  // Driver: strobe a new result and queue the expected slot sequence
  task automatic start_conv(input logic [11:0] d, input logic h, input logic p,
                            input logic u, input logic o, input int scans);
    @(negedge clk);
    #1;
    full_digits = d; half_digit = h; polarity = p; under_range = u; over_range = o;
    eoc_strobe = 1'b1;
    restart_pending = 1'b1;
    q.delete();
    for (int i = 0; i < scans; i++) begin
      q.push_back('{sel: 4'b1000, bus: {o, u, p, h}});   // R8 status word
      q.push_back('{sel: 4'b0100, bus: d[11:8]});        // R7
      q.push_back('{sel: 4'b0010, bus: d[7:4]});
      q.push_back('{sel: 4'b0001, bus: d[3:0]});
    end
    @(negedge clk);
    #1;
    eoc_strobe = 1'b0;
    // R10: scramble the inputs; the captured result must be what appears
    full_digits = ~d; half_digit = ~h; polarity = ~p; under_range = ~u; over_range = ~o;
  endtask

  // Monitor
  logic [3:0] cur_sel = '0;
  logic [3:0] cur_bus = '0;
  int  run_len = 0, zero_len = 0, cyc = 0, last_msd = 0;
  bit  bus_ok = 1'b1, have_prev = 1'b0, msd_valid = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      chk($countones(digit_sel) <= 1, "R4 onehot", digit_sel, 0);
      if (restart_pending) begin
        restart_pending = 1'b0;
        cur_sel = '0; run_len = 0; zero_len = 0; have_prev = 1'b0; msd_valid = 1'b0;
        chk(digit_sel == 4'b1000, "R2/R11 restart at half slot", digit_sel, 4'b1000);
      end
      if (digit_sel != cur_sel) begin
        if (cur_sel != '0) begin
          if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(cur_sel == e.sel, "R3 select order", cur_sel, e.sel);
            chk(cur_bus == e.bus, "R7/R8 slot data", cur_bus, e.bus);
            chk(bus_ok, "R10 bus stable in slot", 0, 1);
            chk(run_len == 18, "R5 hold length", run_len, 18);
          end
          have_prev = 1'b1;
          zero_len = 0;
        end
        if (digit_sel != '0) begin
          if (have_prev) chk(zero_len == 2, "R5 blanking gap", zero_len, 2);
          if (digit_sel == 4'b1000) begin
            if (msd_valid) chk(cyc - last_msd == 80, "R6 scan period", cyc - last_msd, 80);
            last_msd = cyc;
            msd_valid = 1'b1;
          end
          cur_bus = bcd_bus;
          run_len = 1;
          bus_ok = 1'b1;
        end
        cur_sel = digit_sel;
      end else if (digit_sel != '0) begin
        run_len++;
        if (bcd_bus != cur_bus) bus_ok = 1'b0;
      end
      if (digit_sel == '0) begin
        zero_len++;
        chk(bcd_bus == '0, "R9 bus zero when blank", bcd_bus, 0);
      end
    end
  end

  task automatic drain();
    wait (q.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1: idle until the first strobe, even with inputs moving
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      #1;
      full_digits = 12'(i * 37);
      over_range = i[0];
      @(negedge clk);
      chk(digit_sel == '0, "R1 idle selects", digit_sel, 0);
      chk(bcd_bus == '0, "R1 idle bus", bcd_bus, 0);
    end
    start_conv(12'h987, 1'b1, 1'b1, 1'b0, 1'b0, 2);
    drain();
    start_conv(12'h305, 1'b0, 1'b0, 1'b1, 1'b1, 1);
    drain();
    // R11: restart during the third slot
    start_conv(12'h111, 1'b1, 1'b0, 1'b0, 1'b0, 2);
    repeat (44) @(negedge clk);
    start_conv(12'h642, 1'b0, 1'b1, 1'b0, 1'b1, 1);
    drain();
    // R11: restart inside the half-digit hold
    start_conv(12'h999, 1'b1, 1'b1, 1'b1, 1'b1, 1);
    repeat (4) @(negedge clk);
    start_conv(12'h058, 1'b1, 1'b0, 1'b1, 1'b0, 1);
    drain();
    // R11: restart at the first blanking cycle
    start_conv(12'h777, 1'b0, 1'b0, 1'b0, 1'b0, 1);
    repeat (17) @(negedge clk);
    start_conv(12'h420, 1'b1, 1'b1, 1'b0, 1'b0, 2);
    drain();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

endmodule